// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a hardware watchdog for a processor subsystem. A free-running prescaler divides the system clock by a power of two to make a slow tick. With the default setting it divides a 100 MHz clock by 131072, which gives about 763 Hz. While the watchdog runs, an 8-bit counter moves down by one on each tick. Software keeps the chip alive by writing a start command at regular intervals. Each start command reloads the counter from the count in the write. The first start command arms the watchdog, and every later one kicks it.

Every write carries a 7-bit key. After the first command has been accepted, a write only takes effect if its key is the bitwise complement of the key accepted last. A single stray write therefore cannot stop or feed the watchdog. A write with any other key is dropped completely.

If software fails to kick in time, expiry happens in two stages. When the counter reaches 1, the block raises a non-maskable interrupt request, which gives a handler one tick to react. When the counter reaches 0, the block asserts a chip reset. The chip reset stays set until the block's own reset input is applied.

Top module: `kwdog_top`

## Requirements
- R1: After rst_n is released, the watchdog is stopped, wd_count is 0, and nmi_req and chip_rst are both 0. No key is held at this point.
- R2: The key is wr_key[6:0]. The first write after reset is accepted with any key. Each later write is accepted only when wr_key equals the previously accepted key XOR 7'h7F. Every accepted write stores its own key as the new reference.
- R3: A write whose key does not match is ignored. The count, the run state, nmi_req and the stored reference key all keep their previous values.
- R4: An accepted write with wr_cmd=1 (start) loads wd_count from wr_count and sets wd_running, one cycle after the write. This holds both when the watchdog is stopped and when it is already running.
- R5: While the watchdog runs, wd_count decrements once every 2^PRESC_W clock cycles. An accepted start clears the prescaler, so the first decrement after a start comes exactly 2^PRESC_W cycles after that start takes effect.
- R6: An accepted write with wr_cmd=0 (stop) clears wd_running and leaves wd_count frozen at its current value.
- R7: nmi_req rises in the cycle in which the counter becomes 1, whether by a decrement or by a start that loads 1. It then stays high until an accepted start or stop command arrives.
- R8: chip_rst rises in the cycle in which the counter reaches 0, and the watchdog stops at that point. chip_rst stays high until rst_n is applied. While chip_rst is high, every write is ignored, including one with a valid key.
- R9: A start that loads a count of 0 raises chip_rst and nmi_req at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_count | input | 8 | Reload value for the counter |
| wr_cmd | input | 1 | 1 = start/kick, 0 = stop |
| wr_key | input | 7 | Key that comes with the write |
| nmi_req | output | 1 | Non-maskable interrupt request (first stage) |
| chip_rst | output | 1 | Chip reset request (second stage) |
| wd_count | output | 8 | Current counter value |
| wd_running | output | 1 | Watchdog is counting |

## Verification
The hardest case to reach from the ports is a write that carries a correct key while chip_rst is already set. Reaching it requires the whole two-stage expiry to run to completion. The stimulus starts the watchdog with a count of 2 and lets it expire without a kick. It then presents the complement key that would otherwise be accepted, and the bench confirms that the count, the run state and both alarms do not move.

The bench also needs to show that a bad key leaves the stored reference key untouched. To do this, it follows a rejected write with a stop command that carries the complement of the old key, and the bench confirms that this stop takes effect.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
  localparam int KWD_CNT_BITS   = 8;
  localparam int KWD_KEY_BITS   = 7;
  localparam int KWD_PRESC_BITS = 17;

  typedef enum logic {
    WD_CMD_STOP  = 1'b0,
    WD_CMD_START = 1'b1
  } wd_cmd_e;

  typedef struct packed {
    logic go;
    logic halt;
  } wd_accept_t;
endpackage

// File: rtl/kwdog_prescale.sv
module kwdog_prescale #(
  parameter int PRESC_W = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam logic [PRESC_W-1:0] LAST = {PRESC_W{1'b1}};

  logic [PRESC_W-1:0] div_q;

  assign tick = en && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      div_q <= '0;
    end else if (en) begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/kwdog_keygate.sv
module kwdog_keygate
  import kwdog_pkg::*;
#(
  parameter int KEY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_cmd,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             lock,
  output wd_accept_t       acc
);
  logic             have_q;
  logic [KEY_W-1:0] ref_q;
  logic             key_ok;
  logic             take;

  function automatic logic key_follows(input logic [KEY_W-1:0] prev,
                                       input logic [KEY_W-1:0] cand);
    return cand == (prev ^ {KEY_W{1'b1}});
  endfunction

  assign key_ok   = !have_q || key_follows(ref_q, wr_key);
  assign take     = wr_en && !lock && key_ok;
  assign acc.go   = take && (wd_cmd_e'(wr_cmd) == WD_CMD_START);
  assign acc.halt = take && (wd_cmd_e'(wr_cmd) == WD_CMD_STOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      ref_q  <= '0;
    end else if (take) begin
      have_q <= 1'b1;
      ref_q  <= wr_key;
    end
  end
endmodule

// File: rtl/kwdog_core.sv
module kwdog_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             halt,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             nmi,
  output logic             bite
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             nmi_q, nmi_d;
  logic             bite_q, bite_d;
  logic             wrote;
  logic             reach1, reach0;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    wrote = 1'b0;
    if (bite_q) begin
      run_d = 1'b0;
    end else if (go) begin
      cnt_d = load_val;
      run_d = 1'b1;
      wrote = 1'b1;
    end else if (halt) begin
      run_d = 1'b0;
    end else if (tick && run_q && cnt_q != '0) begin
      cnt_d = step_down(cnt_q);
      wrote = 1'b1;
    end
    reach1 = wrote && (cnt_d == {{(CNT_W-1){1'b0}}, 1'b1});
    reach0 = wrote && (cnt_d == '0);
    if (reach0) run_d = 1'b0;
    if (reach1 || reach0)   nmi_d = 1'b1;
    else if (go || halt)    nmi_d = 1'b0;
    else                    nmi_d = nmi_q;
    bite_d = bite_q || reach0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      nmi_q  <= 1'b0;
      bite_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      nmi_q  <= nmi_d;
      bite_q <= bite_d;
    end
  end

  assign cnt  = cnt_q;
  assign run  = run_q;
  assign nmi  = nmi_q;
  assign bite = bite_q;
endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
  import kwdog_pkg::*;
#(
  parameter int CNT_W   = KWD_CNT_BITS,
  parameter int KEY_W   = KWD_KEY_BITS,
  parameter int PRESC_W = KWD_PRESC_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             wr_cmd,
  input  logic [KEY_W-1:0] wr_key,
  output logic             nmi_req,
  output logic             chip_rst,
  output logic [CNT_W-1:0] wd_count,
  output logic             wd_running
);
  wd_accept_t acc;
  logic       acc_start;
  logic       acc_stop;
  logic       tick;

  assign acc_start = acc.go;
  assign acc_stop  = acc.halt;

  kwdog_keygate #(.KEY_W(KEY_W)) u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_cmd (wr_cmd),
    .wr_key (wr_key),
    .lock   (chip_rst),
    .acc    (acc)
  );

  kwdog_prescale #(.PRESC_W(PRESC_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (acc_start),
    .en    (wd_running && !chip_rst),
    .tick  (tick)
  );

  kwdog_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (acc_start),
    .halt     (acc_stop),
    .tick     (tick),
    .load_val (wr_count),
    .cnt      (wd_count),
    .run      (wd_running),
    .nmi      (nmi_req),
    .bite     (chip_rst)
  );
endmodule

// File: rtl/kwdog_chk.sv
module kwdog_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_start,
  input logic             acc_stop,
  input logic             tick,
  input logic [CNT_W-1:0] wr_count,
  input logic [CNT_W-1:0] wd_count,
  input logic             wd_running,
  input logic             nmi_req,
  input logic             chip_rst
);
  assert_one_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_start, acc_stop}));

  assert_start_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> (wd_count == $past(wr_count)) && (wd_running || chip_rst));

  assert_count_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_start && !tick) |=> $stable(wd_count));

  assert_tick_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> wd_running);

  assert_stop_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stop |=> !wd_running);

  assert_nmi_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> (wd_count <= CNT_W'(1)));

  assert_rst_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> chip_rst);

  assert_rst_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_rst) |-> (wd_count == '0) && !wd_running);

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> !acc_start && !acc_stop);
endmodule

bind kwdog_top kwdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_start  (acc_start),
  .acc_stop   (acc_stop),
  .tick       (tick),
  .wr_count   (wr_count),
  .wd_count   (wd_count),
  .wd_running (wd_running),
  .nmi_req    (nmi_req),
  .chip_rst   (chip_rst)
);

// File: tb/sim_kwdog_top.sv
`timescale 1ns/1ps
module sim_kwdog_top;
  localparam int PW  = 3;
  localparam int DIV = 1 << PW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_count = '0;
  logic       wr_cmd = 1'b0;
  logic [6:0] wr_key = '0;
  logic       nmi_req, chip_rst, wd_running;
  logic [7:0] wd_count;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int last_c0 = 0;

  typedef struct {
    int    at;
    int    cnt;
    bit    run;
    bit    nmi;
    bit    rst;
    string tag;
  } exp_t;
  exp_t sb[$];

  kwdog_top #(.PRESC_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_count(wr_count),
    .wr_cmd(wr_cmd), .wr_key(wr_key), .nmi_req(nmi_req), .chip_rst(chip_rst),
    .wd_count(wd_count), .wd_running(wd_running)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void compare(string tag, int ecnt, bit erun, bit enmi, bit erst);
    n_cmp++;
    if (int'(wd_count) != ecnt || wd_running != erun || nmi_req != enmi || chip_rst != erst) begin
      n_bad++;
      $display("FAIL %s: got cnt=%0d run=%0b nmi=%0b rst=%0b, want cnt=%0d run=%0b nmi=%0b rst=%0b",
               tag, wd_count, wd_running, nmi_req, chip_rst, ecnt, erun, enmi, erst);
    end
  endfunction

  function automatic void expect_at(int at, int c, bit r, bit n, bit x, string tag);
    exp_t e;
    e.at = at; e.cnt = c; e.run = r; e.nmi = n; e.rst = x; e.tag = tag;
    sb.push_back(e);
  endfunction

  // monitor: pops items as their cycle arrives
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      if (sb[0].at < cyc) begin
        n_cmp++; n_bad++;
        $display("FAIL %s: sample missed, now %0d expected %0d", sb[0].tag, cyc, sb[0].at);
      end else begin
        compare(sb[0].tag, sb[0].cnt, sb[0].run, sb[0].nmi, sb[0].rst);
      end
      void'(sb.pop_front());
    end
  end

  // driver: one control write, expectation for the cycle it takes effect
  task automatic wr(bit start, int n, int key, int ec, bit er, bit en, bit ex, string tag);
    wr_en    = 1'b1;
    wr_cmd   = start;
    wr_count = n[7:0];
    wr_key   = key[6:0];
    last_c0  = cyc + 1;
    expect_at(last_c0, ec, er, en, ex, tag);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    compare("R1 reset state", 0, 0, 0, 0);
  endtask

  function automatic void finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, cycle %0d expected below 20000", cyc);
    finish_run();
  end

  initial begin
    int c;
    idle(2);
    do_reset();

    // R2: first key arbitrary; R5 first tick after DIV cycles
    wr(1, 5, 'h2A, 5, 1, 0, 0, "R2 first key accepted");
    c = last_c0;
    expect_at(c + DIV - 1, 5, 1, 0, 0, "R5 before tick");
    expect_at(c + DIV,     4, 1, 0, 0, "R5 first decrement");
    drain();

    // R4 restart with complement key
    wr(1, 5, 'h55, 5, 1, 0, 0, "R4 restart reloads");
    // R3: repeated key (not complement) ignored, start and stop
    idle(1);
    wr(1, 9, 'h55, 5, 1, 0, 0, "R3 bad key start ignored");
    wr(0, 0, 'h13, 5, 1, 0, 0, "R3 bad key stop ignored");
    // R3 reference unchanged: complement of 0x55 still works; R6 stop
    wr(0, 0, 'h2A, 5, 0, 0, 0, "R3 R6 stop with kept reference");
    c = last_c0;
    expect_at(c + 4 * DIV, 5, 0, 0, 0, "R6 count frozen");
    drain();

    // R7, R8: expire from 2
    wr(1, 2, 'h55, 2, 1, 0, 0, "R4 start 2");
    c = last_c0;
    expect_at(c + DIV - 1,     2, 1, 0, 0, "R7 no nmi before count 1");
    expect_at(c + DIV,         1, 1, 1, 0, "R7 nmi at count 1");
    expect_at(c + 2 * DIV - 1, 1, 1, 1, 0, "R7 nmi held, no reset yet");
    expect_at(c + 2 * DIV,     0, 0, 1, 1, "R8 reset at count 0");
    drain();
    wr(1, 9, 'h2A, 0, 0, 1, 1, "R8 valid key ignored while reset");
    c = last_c0;
    expect_at(c + 3 * DIV, 0, 0, 1, 1, "R8 reset held");
    drain();

    do_reset();

    // R7 load 1, cleared by start
    wr(1, 1, 'h11, 1, 1, 1, 0, "R7 load one raises nmi");
    idle(2);
    wr(1, 6, 'h6E, 6, 1, 0, 0, "R7 nmi cleared by start");
    drain();

    // R5 prescaler cleared by restart
    wr(1, 3, 'h11, 3, 1, 0, 0, "R4 start 3");
    idle(4);
    wr(1, 3, 'h6E, 3, 1, 0, 0, "R5 mid-period restart");
    c = last_c0;
    expect_at(c + DIV - 1, 3, 1, 0, 0, "R5 full period after restart");
    expect_at(c + DIV,     2, 1, 0, 0, "R5 decrement after restart");
    expect_at(c + 2 * DIV, 1, 1, 1, 0, "R5 R7 second decrement");
    drain();

    // R7 cleared by stop
    wr(0, 0, 'h11, 1, 0, 0, 0, "R7 nmi cleared by stop");
    c = last_c0;
    expect_at(c + 2 * DIV, 1, 0, 0, 0, "R6 stopped holds");
    drain();

    // R9 load zero
    wr(1, 0, 'h6E, 0, 0, 1, 1, "R9 load zero bites at once");
    drain();
    idle(2);
    finish_run();
  end
endmodule